// File: doc/BRIEF.md
# Resumable String Sequencer

The block walks a string in memory one element at a time and moves it, compares it against a second string, or skips over it. Elements are 8, 16 or 32 bits wide. All progress is kept in five visible registers: an element count, a source pointer, a destination pointer, a lookup-table pointer and a match value. Software loads these registers through a load strobe before a start pulse and reads them back afterwards. Every register the engine owns is brought up to date after each element. A pending interrupt can therefore halt the engine between two elements, and a later start carries on exactly where it stopped.

Memory is reached through one request/response port. The engine raises a request, holds its address, direction, size and write data steady, and waits for a one-cycle acknowledge that carries the read data. A four-bit option field selects backward stepping, byte translation through a lookup table, and termination on the match value. That termination fires either when an element equals the value or when it differs from it. The test is made on the element after translation.

The controller is a single state machine. Its states are IDLE, ELEM (element boundary), RDSRC (source read), RDTBL (lookup-table read), TEST (match test), WRDST (destination write), RDDST (destination read for compare), ADV (register update), DONE and SUSP. The transitions are as follows:
- IDLE→ELEM on start with a nonzero count, and IDLE→DONE on start with a zero count.
- ELEM→DONE when the count is zero, ELEM→SUSP on a pending interrupt, and ELEM→RDSRC otherwise.
- RDSRC→RDTBL on acknowledge when translating, and RDSRC→TEST on acknowledge otherwise.
- RDTBL→TEST on acknowledge.
- TEST→DONE when the match condition ends the run. Otherwise TEST goes to WRDST for move, to RDDST for compare and to ADV for skip.
- WRDST→ADV on acknowledge.
- RDDST→ADV on an equal pair, and RDDST→DONE on a mismatch.
- ADV→ELEM always.
- DONE→IDLE and SUSP→IDLE always.

Top module: `strseq_engine`

## Requirements
- R1: `r_count` drops by one after each completed element. When it reaches zero the run ends with `done` high for one cycle and `flag_f` = 0.
- R2: After each element, `r_src` moves by the element size: 1 for size 00, 2 for size 01 and 4 for size 11. `r_dst` moves by the same amount for move and compare. The pointers count upward when `opt[1]` = 0 and downward when `opt[1]` = 1.
- R3: When `opt[0]` = 1 and the size is 00, each source byte v is replaced by the byte at address `r_tbl` + v before it is tested, written or compared. At any other size `opt[0]` has no effect.
- R4: When `opt[2]` = 1, the engine tests the element against `r_match` in the low bits of the element size. With `opt[3]` = 0 it stops on an element that differs, and with `opt[3]` = 1 it stops on an element that is equal. Such a stop sets `flag_f` to 1. The element that caused the stop is not written, and the registers still point at it.
- R5: `op` = 00 (move) writes each element to the destination. `op` = 10 (skip) reads only the source, never writes, leaves `r_dst` unchanged and leaves the count of unskipped elements in `r_count`.
- R6: `op` = 01 (compare) reads the source element and then the destination element. On the first unequal pair it ends with `flag_f` = 0, with the pointers at that pair and with the count not decremented.
- R7: When `irq_pend` is high at an element boundary and the count is nonzero, the engine pulses `suspended` and issues no further access. The count and the pointers then describe exactly the elements already done, and a new start completes the run as if it had never stopped.
- R8: A start with `r_count` = 0 gives `done` on the next cycle with `flag_f` = 0 and no memory request.
- R9: Accesses follow a strict order: source, then table when translating, then destination. Each request keeps its address, direction and size stable until `mem_ack`, and exactly one access is made per acknowledge.
- R10: After reset the engine is idle, with `mem_req`, `done`, `suspended` and `flag_f` low and all registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Loads all five registers while idle |
| ld_count | input | CNT_W | Element count to load |
| ld_src | input | ADDR_W | Source pointer to load |
| ld_dst | input | ADDR_W | Destination pointer to load |
| ld_tbl | input | ADDR_W | Lookup-table pointer to load |
| ld_match | input | 32 | Match value to load |
| start | input | 1 | Begins or resumes a run while idle |
| op | input | 2 | 00 move, 01 compare, 10 skip |
| size | input | 2 | 00 byte, 01 halfword, 11 word |
| opt | input | 4 | [0] translate, [1] backward, [2] match stop, [3] stop on equal |
| irq_pend | input | 1 | Interrupt pending, honoured between elements |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Access size, same encoding as `size` |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Acknowledge; read data is valid in this cycle |
| mem_rdata | input | 32 | Read data, right-aligned and zero-extended |
| r_count | output | CNT_W | Remaining element count |
| r_src | output | ADDR_W | Source pointer |
| r_dst | output | ADDR_W | Destination pointer |
| r_tbl | output | ADDR_W | Lookup-table pointer |
| r_match | output | 32 | Match value |
| flag_f | output | 1 | Termination flag |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle pulse when a run ends |
| suspended | output | 1 | One-cycle pulse when a run is halted by an interrupt |

## Verification
The hardest case to reach is a halt in the middle of a string, followed by a resume whose accesses and final state must match an uninterrupted run. The bench raises `irq_pend` a fixed number of cycles after start, while the memory model varies its acknowledge latency. As a result the halt lands after an element count that the bench does not fix in advance. It then checks the halted registers against the number of elements consumed and restarts with no reload. The expected-access queue of one uninterrupted run must still drain in order. A separate run holds the interrupt high from before start, so the engine halts before its first access.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    localparam int ELEM_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b11;

    localparam logic [1:0] OP_MOVE = 2'b00;
    localparam logic [1:0] OP_CMP  = 2'b01;
    localparam logic [1:0] OP_SKIP = 2'b10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ELEM,
        S_RDSRC,
        S_RDTBL,
        S_TEST,
        S_WRDST,
        S_RDDST,
        S_ADV,
        S_DONE,
        S_SUSP
    } seq_state_e;

    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: elem_bytes = 3'd1;
            SZ_HALF: elem_bytes = 3'd2;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [ELEM_W-1:0] elem_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: elem_mask = 32'h0000_00FF;
            SZ_HALF: elem_mask = 32'h0000_FFFF;
            default: elem_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/strseq_step.sv
module strseq_step
    import strseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [1:0]        sz,
    input  logic              back,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] stride;

    always_comb begin
        stride = ADDR_W'(elem_bytes(sz));
        nxt    = back ? (ptr - stride) : (ptr + stride);
    end
endmodule

// File: rtl/strseq_match.sv
module strseq_match
    import strseq_pkg::*;
(
    input  logic [ELEM_W-1:0] lhs,
    input  logic [ELEM_W-1:0] rhs,
    input  logic [1:0]        sz,
    output logic              same
);
    always_comb begin
        same = ((lhs ^ rhs) & elem_mask(sz)) == '0;
    end
endmodule

// File: rtl/strseq_engine.sv
module strseq_engine
    import strseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [ADDR_W-1:0] ld_tbl,
    input  logic [31:0]       ld_match,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [1:0]        size,
    input  logic [3:0]        opt,
    input  logic              irq_pend,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [CNT_W-1:0]  r_count,
    output logic [ADDR_W-1:0] r_src,
    output logic [ADDR_W-1:0] r_dst,
    output logic [ADDR_W-1:0] r_tbl,
    output logic [31:0]       r_match,
    output logic              flag_f,
    output logic              busy,
    output logic              done,
    output logic              suspended
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_e state, state_nxt;

    logic [1:0]        op_q;
    logic [1:0]        sz_q;
    logic [3:0]        opt_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] src_q, dst_q, tbl_q;
    logic [31:0]       mat_q;
    logic [31:0]       val_q;
    logic              f_q;

    logic              xlate_on;
    logic              r4_same;
    logic              pair_same;
    logic              match_stop;
    logic [ADDR_W-1:0] src_step, dst_step;

    assign xlate_on = opt_q[0] && (sz_q == SZ_BYTE);

    strseq_step #(.ADDR_W(ADDR_W)) u_step_src (
        .ptr (src_q),
        .sz  (sz_q),
        .back(opt_q[1]),
        .nxt (src_step)
    );

    strseq_step #(.ADDR_W(ADDR_W)) u_step_dst (
        .ptr (dst_q),
        .sz  (sz_q),
        .back(opt_q[1]),
        .nxt (dst_step)
    );

    strseq_match u_match_r4 (
        .lhs (val_q),
        .rhs (mat_q),
        .sz  (sz_q),
        .same(r4_same)
    );

    strseq_match u_match_pair (
        .lhs (val_q),
        .rhs (mem_rdata),
        .sz  (sz_q),
        .same(pair_same)
    );

    assign match_stop = opt_q[2] && (opt_q[3] ? r4_same : !r4_same);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (start) state_nxt = (cnt_q == '0) ? S_DONE : S_ELEM;
            S_ELEM: begin
                if (cnt_q == '0)   state_nxt = S_DONE;
                else if (irq_pend) state_nxt = S_SUSP;
                else               state_nxt = S_RDSRC;
            end
            S_RDSRC: if (mem_ack) state_nxt = xlate_on ? S_RDTBL : S_TEST;
            S_RDTBL: if (mem_ack) state_nxt = S_TEST;
            S_TEST: begin
                if (match_stop)          state_nxt = S_DONE;
                else if (op_q == OP_MOVE) state_nxt = S_WRDST;
                else if (op_q == OP_CMP)  state_nxt = S_RDDST;
                else                     state_nxt = S_ADV;
            end
            S_WRDST: if (mem_ack) state_nxt = S_ADV;
            S_RDDST: if (mem_ack) state_nxt = pair_same ? S_ADV : S_DONE;
            S_ADV:   state_nxt = S_ELEM;
            S_DONE:  state_nxt = S_IDLE;
            S_SUSP:  state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_q;
        mem_size  = sz_q;
        mem_wdata = val_q & elem_mask(sz_q);
        unique case (state)
            S_RDSRC: mem_req = 1'b1;
            S_RDTBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_q + ADDR_W'(val_q[7:0]);
                mem_size = SZ_BYTE;
            end
            S_WRDST: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
            end
            S_RDDST: begin
                mem_req  = 1'b1;
                mem_addr = dst_q;
            end
            default: ;
        endcase
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        suspended = (state == S_SUSP);
    end

    // Architectural registers and element datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_MOVE;
            sz_q  <= SZ_BYTE;
            opt_q <= '0;
            cnt_q <= '0;
            src_q <= '0;
            dst_q <= '0;
            tbl_q <= '0;
            mat_q <= '0;
            val_q <= '0;
            f_q   <= 1'b0;
        end else begin
            if (state == S_IDLE && ld_en) begin
                cnt_q <= ld_count;
                src_q <= ld_src;
                dst_q <= ld_dst;
                tbl_q <= ld_tbl;
                mat_q <= ld_match;
            end
            if (state == S_IDLE && start) begin
                op_q  <= op;
                sz_q  <= size;
                opt_q <= opt;
            end
            if (state == S_RDSRC && mem_ack) val_q <= mem_rdata & elem_mask(sz_q);
            if (state == S_RDTBL && mem_ack) val_q <= {24'h0, mem_rdata[7:0]};
            if (state == S_ADV) begin
                cnt_q <= cnt_q - CNT_ONE;
                src_q <= src_step;
                if (op_q != OP_SKIP) dst_q <= dst_step;
            end
            if (state_nxt == S_DONE) f_q <= (state == S_TEST);
        end
    end

    assign r_count = cnt_q;
    assign r_src   = src_q;
    assign r_dst   = dst_q;
    assign r_tbl   = tbl_q;
    assign r_match = mat_q;
    assign flag_f  = f_q;

    // R1: each register update consumes exactly one element
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADV) |=> (r_count == $past(r_count) - CNT_ONE));

    // R4: a set flag only comes from a run with match termination enabled
    p_flag_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_f) |-> opt_q[2]);

    // R5: only a move ever writes memory
    p_write_only_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (op_q == OP_MOVE));

    // R7: a pending interrupt at a boundary halts the run next cycle
    p_irq_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ELEM && cnt_q != '0 && irq_pend) |=> (suspended && !mem_req));

    // R8: a start with an empty count ends at once without memory traffic
    p_zero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && r_count == '0) |=> (done && !mem_req && !flag_f));

    // R9: an unacknowledged request holds its controls
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

endmodule

// File: tb/test_strseq_engine.sv
`timescale 1ns/1ps
module test_strseq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_count = '0, ld_src = '0, ld_dst = '0, ld_tbl = '0, ld_match = '0;
    logic        start = 1'b0;
    logic [1:0]  op = '0, size = '0;
    logic [3:0]  opt = '0;
    logic        irq_pend = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] r_count, r_src, r_dst, r_tbl, r_match;
    logic        flag_f, busy, done, suspended;

    int n_chk = 0;
    int n_err = 0;
    int n_acc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    strseq_engine i_strseq_engine (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_count(ld_count), .ld_src(ld_src),
        .ld_dst(ld_dst), .ld_tbl(ld_tbl), .ld_match(ld_match), .start(start), .op(op),
        .size(size), .opt(opt), .irq_pend(irq_pend), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .r_count(r_count), .r_src(r_src), .r_dst(r_dst),
        .r_tbl(r_tbl), .r_match(r_match), .flag_f(flag_f), .busy(busy), .done(done),
        .suspended(suspended)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        we;
        logic [1:0]  sz;
        logic [31:0] d;
    } acc_t;

    acc_t        expq[$];
    logic [7:0]  mem  [0:1023];
    logic [7:0]  rmem [0:1023];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a, input logic [31:0] nb);
        logic [31:0] v = '0;
        for (int k = 0; k < 4; k++)
            if (32'(k) < nb) v = v | (32'(mem[10'(a + 32'(k))]) << (8 * k));
        return v;
    endfunction

    function automatic logic [31:0] rrd(input logic [31:0] a, input logic [31:0] nb);
        logic [31:0] v = '0;
        for (int k = 0; k < 4; k++)
            if (32'(k) < nb) v = v | (32'(rmem[10'(a + 32'(k))]) << (8 * k));
        return v;
    endfunction

    // Memory model: variable latency, one acknowledge per access, checks access order (R9)
    logic [1:0] lat_sel = '0;
    logic [1:0] lat_cnt = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt < lat_sel) begin
                lat_cnt <= lat_cnt + 2'd1;
            end else begin
                acc_t e;
                logic [31:0] nb;
                lat_cnt <= '0;
                lat_sel <= (lat_sel == 2'd2) ? 2'd0 : lat_sel + 2'd1;
                nb = nbytes(mem_size);
                n_acc++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 unexpected access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    e = expq.pop_front();
                    chk(mem_addr == e.a, "R9 access address", mem_addr, e.a);
                    chk(mem_we == e.we && mem_size == e.sz, "R9 access kind",
                        {29'h0, mem_we, mem_size}, {29'h0, e.we, e.sz});
                    if (e.we) chk((mem_wdata & ((nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1))) == e.d,
                                  "R5 write data", mem_wdata, e.d);
                end
                if (mem_we) begin
                    for (int k = 0; k < 4; k++)
                        if (32'(k) < nb) mem[10'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
                end else begin
                    mem_rdata <= mrd(mem_addr, nb);
                end
                mem_ack <= 1'b1;
            end
        end
    end

    // Behavioural reference of one uninterrupted run
    task automatic model(input logic [1:0] o, input logic [1:0] sz, input logic [3:0] pt,
                         input logic [31:0] c0, input logic [31:0] s0, input logic [31:0] d0,
                         input logic [31:0] t0, input logic [31:0] m0,
                         output logic [31:0] c, output logic [31:0] s, output logic [31:0] d,
                         output bit f);
        logic [31:0] nb, msk, v, w;
        bit tr, fin;
        nb  = nbytes(sz);
        msk = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
        tr  = pt[0] && (sz == 2'b00);
        c = c0; s = s0; d = d0; f = 1'b0; fin = 1'b0;
        while (c != 0 && !fin) begin
            v = rrd(s, nb);
            expq.push_back('{s, 1'b0, sz, 32'h0});
            if (tr) begin
                expq.push_back('{t0 + v, 1'b0, 2'b00, 32'h0});
                v = 32'(rmem[10'(t0 + v)]);
            end
            if (pt[2] && (pt[3] ? (v == (m0 & msk)) : (v != (m0 & msk)))) begin
                f = 1'b1;
                fin = 1'b1;
            end else begin
                if (o == 2'b00) begin
                    expq.push_back('{d, 1'b1, sz, v});
                    for (int k = 0; k < 4; k++)
                        if (32'(k) < nb) rmem[10'(d + 32'(k))] = v[8*k +: 8];
                end else if (o == 2'b01) begin
                    expq.push_back('{d, 1'b0, sz, 32'h0});
                    w = rrd(d, nb);
                    if (w != v) fin = 1'b1;
                end
                if (!fin) begin
                    c = c - 1;
                    s = pt[1] ? s - nb : s + nb;
                    if (o != 2'b10) d = pt[1] ? d - nb : d + nb;
                end
            end
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [7:0] b);
        mem[10'(a)]  = b;
        rmem[10'(a)] = b;
    endtask

    task automatic load(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] t, input logic [31:0] m);
        @(negedge clk);
        ld_en = 1'b1; ld_count = c; ld_src = s; ld_dst = d; ld_tbl = t; ld_match = m;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic go(input logic [1:0] o, input logic [1:0] sz, input logic [3:0] pt);
        op = o; size = sz; opt = pt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_susp);
        got_done = 1'b0; got_susp = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done || suspended) begin
                got_done = done;
                got_susp = suspended;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_end(input string tag, input bit gd, input logic [31:0] ec,
                             input logic [31:0] es, input logic [31:0] ed, input bit ef);
        int bad = 0;
        chk(gd, {tag, " done pulse"}, {31'h0, gd}, 32'h1);
        chk(r_count == ec, {tag, " count"}, r_count, ec);
        chk(r_src == es, {tag, " source pointer"}, r_src, es);
        chk(r_dst == ed, {tag, " destination pointer"}, r_dst, ed);
        chk(flag_f == ef, {tag, " flag"}, {31'h0, flag_f}, {31'h0, ef});
        chk(expq.size() == 0, {tag, " accesses left (R9)"}, 32'(expq.size()), 32'h0);
        for (int k = 0; k < 1024; k++) if (mem[k] != rmem[k]) bad++;
        chk(bad == 0, {tag, " memory image"}, 32'(bad), 32'h0);
    endtask

    task automatic run_op(input string tag, input logic [1:0] o, input logic [1:0] sz,
                          input logic [3:0] pt, input logic [31:0] c0, input logic [31:0] s0,
                          input logic [31:0] d0, input logic [31:0] t0, input logic [31:0] m0);
        logic [31:0] ec, es, ed;
        bit ef, gd, gs;
        load(c0, s0, d0, t0, m0);
        model(o, sz, pt, c0, s0, d0, t0, m0, ec, es, ed, ef);
        go(o, sz, pt);
        wait_end(gd, gs);
        check_end(tag, gd, ec, es, ed, ef);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        logic [31:0] ec, es, ed;
        bit ef, gd, gs;
        int acc0;
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 8'(i * 13 + 5);
            rmem[i] = 8'(i * 13 + 5);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!mem_req && !busy && !done && !suspended, "R10 idle outputs",
            {28'h0, mem_req, busy, done, suspended}, 32'h0);
        chk(!flag_f && r_count == 0 && r_src == 0 && r_dst == 0, "R10 registers cleared",
            r_count | r_src | r_dst, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R5 R1 move bytes forward", 2'b00, 2'b00, 4'b0000, 5, 32'h100, 32'h200, 32'h300, 0);
        run_op("R2 move halfwords backward", 2'b00, 2'b01, 4'b0010, 4, 32'h15E, 32'h25E, 32'h300, 0);
        run_op("R2 move words forward", 2'b00, 2'b11, 4'b0000, 3, 32'h100, 32'h2E0, 32'h300, 0);
        run_op("R3 move translated bytes", 2'b00, 2'b00, 4'b0001, 6, 32'h100, 32'h210, 32'h300, 0);

        for (int i = 0; i < 8; i++) put(32'h100 + 32'(i), 8'(8'h41 + i));
        run_op("R4 stop on equal", 2'b00, 2'b00, 4'b1100, 8, 32'h100, 32'h220, 32'h300, 32'h44);

        // R8: empty count completes at once, flag cleared, no access
        acc0 = n_acc;
        load(0, 32'h100, 32'h200, 32'h300, 0);
        go(2'b00, 2'b00, 4'b0000);
        chk(done && !mem_req, "R8 done one cycle after start", {30'h0, done, mem_req}, 32'h2);
        chk(!flag_f, "R8 flag cleared", {31'h0, flag_f}, 32'h0);
        @(negedge clk);
        chk(n_acc == acc0 && r_count == 0, "R8 no memory access", 32'(n_acc - acc0), 32'h0);

        for (int i = 0; i < 5; i++) begin
            put(32'h140 + 32'(2 * i), 8'h20);
            put(32'h141 + 32'(2 * i), 8'h20);
        end
        put(32'h144, 8'h41);
        run_op("R4 stop on difference", 2'b00, 2'b01, 4'b0100, 5, 32'h140, 32'h230, 32'h300, 32'h2020);

        for (int i = 0; i < 6; i++) put(32'h160 + 32'(i), (i < 3) ? 8'h20 : 8'h78);
        run_op("R5 skip leading blanks", 2'b10, 2'b00, 4'b0100, 6, 32'h160, 32'h250, 32'h300, 32'h20);

        for (int i = 0; i < 12; i++) begin
            put(32'h180 + 32'(i), 8'(i * 7 + 1));
            put(32'h280 + 32'(i), 8'(i * 7 + 1));
        end
        run_op("R6 compare equal words", 2'b01, 2'b11, 4'b0000, 3, 32'h180, 32'h280, 32'h300, 0);

        for (int i = 0; i < 6; i++) begin
            put(32'h1A0 + 32'(i), 8'(8'h61 + i));
            put(32'h2A0 + 32'(i), (i == 3) ? 8'h5A : 8'(8'h61 + i));
        end
        run_op("R6 compare mismatch", 2'b01, 2'b00, 4'b0000, 6, 32'h1A0, 32'h2A0, 32'h300, 0);

        for (int i = 0; i < 4; i++) put(32'h1C0 + 32'(i), 8'(i + 1));
        run_op("R1 no match count exhausted", 2'b00, 2'b00, 4'b1100, 4, 32'h1C0, 32'h2C0, 32'h300, 32'hEE);

        run_op("R3 translate ignored at halfword", 2'b00, 2'b01, 4'b0001, 3, 32'h120, 32'h2D0, 32'h300, 0);

        // R7: interrupt pending before start halts before any access
        acc0 = n_acc;
        load(3, 32'h108, 32'h330, 32'h300, 0);
        model(2'b00, 2'b00, 4'b0000, 3, 32'h108, 32'h330, 32'h300, 0, ec, es, ed, ef);
        irq_pend = 1'b1;
        go(2'b00, 2'b00, 4'b0000);
        wait_end(gd, gs);
        chk(gs && !gd, "R7 immediate halt pulse", {30'h0, gd, gs}, 32'h1);
        chk(n_acc == acc0 && r_count == 3, "R7 immediate halt no access", r_count, 32'h3);
        @(negedge clk);
        irq_pend = 1'b0;
        go(2'b00, 2'b00, 4'b0000);
        wait_end(gd, gs);
        check_end("R7 resume after immediate halt", gd, ec, es, ed, ef);

        // R7: interrupt in mid string, then resume
        load(8, 32'h100, 32'h340, 32'h300, 0);
        model(2'b00, 2'b00, 4'b0000, 8, 32'h100, 32'h340, 32'h300, 0, ec, es, ed, ef);
        go(2'b00, 2'b00, 4'b0000);
        repeat (12) @(negedge clk);
        irq_pend = 1'b1;
        wait_end(gd, gs);
        chk(gs, "R7 mid-string halt pulse", {31'h0, gs}, 32'h1);
        chk(r_count > 0 && r_count < 8, "R7 halted part way", r_count, 32'h4);
        chk(r_src == 32'h100 + (8 - r_count), "R7 source consistent", r_src, 32'h100 + (8 - r_count));
        chk(r_dst == 32'h340 + (8 - r_count), "R7 destination consistent", r_dst, 32'h340 + (8 - r_count));
        @(negedge clk);
        chk(!mem_req && !busy, "R7 quiet after halt", {30'h0, mem_req, busy}, 32'h0);
        irq_pend = 1'b0;
        go(2'b00, 2'b00, 4'b0000);
        wait_end(gd, gs);
        check_end("R7 resume mid-string", gd, ec, es, ed, ef);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule